// File: doc/BRIEF.md
# Single-Wire Bus Master Engine

This block drives a single-wire, open-drain serial bus from a 32-bit register port. Each bus operation is one timed pulse. The engine pulls the line low for a programmed number of microseconds, then releases it. A programmed number of microseconds after the release it samples the line. It then waits a fixed recovery interval and raises a completion flag. Software can launch such a pulse directly by writing one word that carries both the low width and the post-release sample delay. The word itself is the timing, so no separate slot timers are needed.

A small command sequencer sits on top of the pulse primitive. It offers four operations:

- a bus reset whose sampled bit reports device presence;
- a single-bit write;
- an eight-slot byte read assembled least significant bit first;
- the search triplet, which reads a bit and its complement and then writes a direction bit chosen from the two.

Time is measured in ticks of a one-microsecond strobe supplied from outside. The line input is resynchronised before use.

Top module: `onewire_master`

## Requirements
- R1: After reset the line enable is low, and both registers read 0: address 0 (pulse word) and address 1 (command/result).
- R2: A write to address 0 with low width W in bits [19:10] and sample delay S in bits [9:2] drives lineOe high for exactly W ticks. The line is then sampled S ticks after release, and the sampled level is reported in bit 0 of both registers. Address 0 reads back W and S in the same positions.
- R3: A pulse is followed by RECOVERY_US ticks (default 500) of recovery. Only then is the done flag (bit 1 of both registers) set, or the next pulse of a command started. Within a command, the gap from the end of one low phase to the start of the next is S + RECOVERY_US ticks.
- R4: A width or sample field of 0 behaves as 1 tick.
- R5: A write to either address while an operation is in progress is ignored: no extra pulse starts and the pulse fields are unchanged. An accepted write clears the done flag.
- R6: Command opcode 0 (bits [1:0] of an address-1 write) performs a reset pulse: 500 ticks low, sample 65 ticks after release. The sampled bit goes to result bit 8, where 0 means a device answered.
- R7: Opcode 1 writes the bit in bit 2. A 1 uses a 6-tick low phase with a 110-tick sample delay. A 0 uses 80 ticks low with a 30-tick sample delay. The sampled bit goes to result bit 8.
- R8: Opcode 2 performs eight read slots, each 6 ticks low with a 13-tick sample delay. The first sampled bit lands in result bit 8 and the last in bit 15.
- R9: Opcode 3 performs two read slots, placing the first sample in result bit 9 and the second in bit 8. It then writes one bit: the direction in bit 2 if both samples were 0, a 0 if only the second was 1, and a 1 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 1 | Register select: 0 pulse word, 1 command/result |
| regWData | input | 32 | Write data |
| regRData | output | 32 | Read data for the selected register (combinational) |
| usTick | input | 1 | One-cycle strobe per microsecond |
| lineIn | input | 1 | Bus line level (asynchronous) |
| lineOe | output | 1 | Pull the bus line low when high |

## Verification
The low-phase length of every pulse is due in tick units at the falling edge of lineOe. The gap between consecutive pulses of one command is due exactly S + RECOVERY_US ticks after the previous release. A scoreboard therefore queues each expected pulse and compares both counts at the lineOe edges the moment they occur. Register results are only valid once the done flag rises, which is the cycle after the recovery interval ends. The bench polls that flag on falling clock edges and compares the full register word only after it reads 1. Done clearing and ignored writes are checked on the cycle immediately after the write is accepted.

// File: rtl/owm_pkg.sv
package owm_pkg;

  // Register field placement (decoded by software)
  localparam int FIELD_SMP_LSB = 2;
  localparam int FIELD_WID_LSB = 10;
  localparam int DONE_BIT      = 1;
  localparam int LINE_BIT      = 0;
  localparam int RESULT_LSB    = 8;
  localparam int CMD_ARG_BIT   = 2;

  localparam int BYTE_BITS = 8;

  // Standard slot timings in microseconds
  localparam int RST_LOW_US  = 500;
  localparam int RST_SMP_US  = 65;
  localparam int WR1_LOW_US  = 6;
  localparam int WR1_SMP_US  = 110;
  localparam int WR0_LOW_US  = 80;
  localparam int WR0_SMP_US  = 30;
  localparam int RD_LOW_US   = 6;
  localparam int RD_SMP_US   = 13;

  typedef enum logic [2:0] {
    PS_RAW,
    PS_RESET,
    PS_WR1,
    PS_WR0,
    PS_READ
  } pulseSel_e;

  typedef enum logic [1:0] {
    OP_RESET   = 2'd0,
    OP_WRBIT   = 2'd1,
    OP_RDBYTE  = 2'd2,
    OP_TRIPLET = 2'd3
  } cmdOp_e;

  // Strobes from the sequencer to the datapath and pulse engine
  typedef struct packed {
    logic      startPulse;
    pulseSel_e sel;
    logic      loadRaw;
    logic      clrDone;
    logic      setDone;
    logic      clrResult;
    logic      shiftLeft;
    logic      shiftRight;
  } ctrlStb_t;

endpackage

// File: rtl/owm_pulse.sv
module owm_pulse #(
  parameter int WIDTH_BITS  = 10,
  parameter int SAMPLE_BITS = 8,
  parameter int RECOVERY_US = 500
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   usTick,
  input  logic                   lineIn,
  input  logic                   start,
  input  logic [WIDTH_BITS-1:0]  lowUs,
  input  logic [SAMPLE_BITS-1:0] smpUs,
  output logic                   busy,
  output logic                   lineOe,
  output logic                   pulseDone,
  output logic                   pulseBit
);

  localparam int REC_W  = $clog2(RECOVERY_US + 1);
  localparam int MAX_WS = (WIDTH_BITS > SAMPLE_BITS) ? WIDTH_BITS : SAMPLE_BITS;
  localparam int CNT_W  = (MAX_WS > REC_W) ? MAX_WS : REC_W;

  typedef enum logic [1:0] {PH_IDLE, PH_LOW, PH_REL, PH_REC} phase_e;

  phase_e           phase;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lowLen;
  logic [CNT_W-1:0] smpLen;
  logic [1:0]       syncQ;
  logic             lineSync;

  // Two-flop resynchroniser; idle line is high
  always_ff @(posedge clk) begin
    if (!rstN) syncQ <= 2'b11;
    else       syncQ <= {syncQ[0], lineIn};
  end
  assign lineSync = syncQ[1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase     <= PH_IDLE;
      cnt       <= '0;
      lowLen    <= '0;
      smpLen    <= '0;
      pulseDone <= 1'b0;
      pulseBit  <= 1'b0;
    end else begin
      pulseDone <= 1'b0;
      unique case (phase)
        PH_IDLE: begin
          if (start) begin
            phase  <= PH_LOW;
            cnt    <= '0;
            lowLen <= (lowUs == '0) ? CNT_W'(1) : CNT_W'(lowUs);
            smpLen <= (smpUs == '0) ? CNT_W'(1) : CNT_W'(smpUs);
          end
        end
        PH_LOW: begin
          if (usTick) begin
            if (cnt + CNT_W'(1) == lowLen) begin
              phase <= PH_REL;
              cnt   <= '0;
            end else begin
              cnt <= cnt + CNT_W'(1);
            end
          end
        end
        PH_REL: begin
          if (usTick) begin
            if (cnt + CNT_W'(1) == smpLen) begin
              pulseBit <= lineSync;
              phase    <= PH_REC;
              cnt      <= '0;
            end else begin
              cnt <= cnt + CNT_W'(1);
            end
          end
        end
        PH_REC: begin
          if (usTick) begin
            if (cnt + CNT_W'(1) == CNT_W'(RECOVERY_US)) begin
              phase     <= PH_IDLE;
              pulseDone <= 1'b1;
              cnt       <= '0;
            end else begin
              cnt <= cnt + CNT_W'(1);
            end
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign busy   = (phase != PH_IDLE);
  assign lineOe = (phase == PH_LOW);

  // R2
  oe_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lineOe) |-> $past(start));

  // R5
  start_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    start |-> !busy);

  // R3
  done_released_chk: assert property (@(posedge clk) disable iff (!rstN)
    pulseDone |-> !lineOe);

endmodule

// File: rtl/owm_control.sv
module owm_control
  import owm_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     regWr,
  input  logic     regAddr,
  input  logic [1:0] cmdOp,
  input  logic     cmdArg,
  input  logic     pulseDone,
  input  logic     pulseBit,
  input  logic     firstBit,
  output ctrlStb_t stb,
  output logic     busy
);

  localparam int CNT_W = $clog2(BYTE_BITS);
  localparam logic [CNT_W-1:0] LAST_SLOT = CNT_W'(BYTE_BITS - 1);

  typedef enum logic [2:0] {
    ST_IDLE, ST_RAW, ST_RESET, ST_WBIT, ST_RBYTE, ST_TRI_A, ST_TRI_B, ST_TRI_W
  } state_e;

  state_e           state, nextState;
  logic [CNT_W-1:0] bitCnt;
  logic             dirQ;

  always_comb begin
    stb       = '0;
    stb.sel   = PS_RAW;
    nextState = state;
    unique case (state)
      ST_IDLE: begin
        if (regWr) begin
          stb.clrDone    = 1'b1;
          stb.startPulse = 1'b1;
          if (!regAddr) begin
            stb.loadRaw = 1'b1;
            stb.sel     = PS_RAW;
            nextState   = ST_RAW;
          end else begin
            stb.clrResult = 1'b1;
            unique case (cmdOp_e'(cmdOp))
              OP_RESET: begin
                stb.sel   = PS_RESET;
                nextState = ST_RESET;
              end
              OP_WRBIT: begin
                stb.sel   = cmdArg ? PS_WR1 : PS_WR0;
                nextState = ST_WBIT;
              end
              OP_RDBYTE: begin
                stb.sel   = PS_READ;
                nextState = ST_RBYTE;
              end
              default: begin
                stb.sel   = PS_READ;
                nextState = ST_TRI_A;
              end
            endcase
          end
        end
      end
      ST_RAW: begin
        if (pulseDone) begin
          stb.setDone = 1'b1;
          nextState   = ST_IDLE;
        end
      end
      ST_RESET, ST_WBIT: begin
        if (pulseDone) begin
          stb.shiftLeft = 1'b1;
          stb.setDone   = 1'b1;
          nextState     = ST_IDLE;
        end
      end
      ST_RBYTE: begin
        if (pulseDone) begin
          stb.shiftRight = 1'b1;
          if (bitCnt == LAST_SLOT) begin
            stb.setDone = 1'b1;
            nextState   = ST_IDLE;
          end else begin
            stb.startPulse = 1'b1;
            stb.sel        = PS_READ;
          end
        end
      end
      ST_TRI_A: begin
        if (pulseDone) begin
          stb.shiftLeft  = 1'b1;
          stb.startPulse = 1'b1;
          stb.sel        = PS_READ;
          nextState      = ST_TRI_B;
        end
      end
      ST_TRI_B: begin
        if (pulseDone) begin
          stb.shiftLeft  = 1'b1;
          stb.startPulse = 1'b1;
          unique case ({firstBit, pulseBit})
            2'b00:   stb.sel = dirQ ? PS_WR1 : PS_WR0;
            2'b01:   stb.sel = PS_WR0;
            default: stb.sel = PS_WR1;
          endcase
          nextState = ST_TRI_W;
        end
      end
      ST_TRI_W: begin
        if (pulseDone) begin
          stb.setDone = 1'b1;
          nextState   = ST_IDLE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
      dirQ   <= 1'b0;
    end else begin
      state <= nextState;
      if (state == ST_IDLE) begin
        bitCnt <= '0;
        if (regWr && regAddr) dirQ <= cmdArg;
      end else if (state == ST_RBYTE && pulseDone) begin
        bitCnt <= bitCnt + CNT_W'(1);
      end
    end
  end

  assign busy = (state != ST_IDLE);

  // R5
  accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.startPulse |-> ((state == ST_IDLE) && regWr) || pulseDone);

  // R8
  shift_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.shiftLeft, stb.shiftRight, stb.clrResult}));

  // R9
  tri_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_TRI_W) |-> $past(state == ST_TRI_W || state == ST_TRI_B));

endmodule

// File: rtl/owm_datapath.sv
module owm_datapath
  import owm_pkg::*;
#(
  parameter int WIDTH_BITS  = 10,
  parameter int SAMPLE_BITS = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   regWr,
  input  logic                   regAddr,
  input  logic [31:0]            regWData,
  input  ctrlStb_t               stb,
  input  logic                   ctrlBusy,
  input  logic                   pulseDone,
  input  logic                   pulseBit,
  output logic [WIDTH_BITS-1:0]  lowUs,
  output logic [SAMPLE_BITS-1:0] smpUs,
  output logic                   firstBit,
  output logic [31:0]            regRData
);

  localparam int WID_TOP = FIELD_WID_LSB + WIDTH_BITS;

  logic [WIDTH_BITS-1:0]  rawW;
  logic [SAMPLE_BITS-1:0] rawS;
  logic [BYTE_BITS-1:0]   result;
  logic                   doneFlag;
  logic                   lastBit;
  logic                   unusedWrBits;

  assign unusedWrBits = ^{regWData[31:WID_TOP], regWData[FIELD_SMP_LSB-1:0]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rawW     <= '0;
      rawS     <= '0;
      result   <= '0;
      doneFlag <= 1'b0;
      lastBit  <= 1'b0;
    end else begin
      if (stb.loadRaw) begin
        rawW <= regWData[FIELD_WID_LSB +: WIDTH_BITS];
        rawS <= regWData[FIELD_SMP_LSB +: SAMPLE_BITS];
      end
      if (stb.clrDone)      doneFlag <= 1'b0;
      else if (stb.setDone) doneFlag <= 1'b1;
      if (pulseDone) lastBit <= pulseBit;
      if (stb.clrResult)       result <= '0;
      else if (stb.shiftLeft)  result <= {result[BYTE_BITS-2:0], pulseBit};
      else if (stb.shiftRight) result <= {pulseBit, result[BYTE_BITS-1:1]};
    end
  end

  // Timing selection for the pulse about to start
  always_comb begin
    unique case (stb.sel)
      PS_RESET: begin
        lowUs = WIDTH_BITS'(RST_LOW_US);
        smpUs = SAMPLE_BITS'(RST_SMP_US);
      end
      PS_WR1: begin
        lowUs = WIDTH_BITS'(WR1_LOW_US);
        smpUs = SAMPLE_BITS'(WR1_SMP_US);
      end
      PS_WR0: begin
        lowUs = WIDTH_BITS'(WR0_LOW_US);
        smpUs = SAMPLE_BITS'(WR0_SMP_US);
      end
      PS_READ: begin
        lowUs = WIDTH_BITS'(RD_LOW_US);
        smpUs = SAMPLE_BITS'(RD_SMP_US);
      end
      default: begin
        lowUs = regWData[FIELD_WID_LSB +: WIDTH_BITS];
        smpUs = regWData[FIELD_SMP_LSB +: SAMPLE_BITS];
      end
    endcase
  end

  assign firstBit = result[0];

  always_comb begin
    regRData = '0;
    if (!regAddr) begin
      regRData[FIELD_WID_LSB +: WIDTH_BITS]  = rawW;
      regRData[FIELD_SMP_LSB +: SAMPLE_BITS] = rawS;
    end else begin
      regRData[RESULT_LSB +: BYTE_BITS] = result;
    end
    regRData[DONE_BIT] = doneFlag;
    regRData[LINE_BIT] = lastBit;
  end

  // R5
  raw_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && ctrlBusy) |=> ($stable(rawW) && $stable(rawS)));

  // R3
  done_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(doneFlag) |-> $past(pulseDone));

endmodule

// File: rtl/onewire_master.sv
module onewire_master
  import owm_pkg::*;
#(
  parameter int WIDTH_BITS  = 10,
  parameter int SAMPLE_BITS = 8,
  parameter int RECOVERY_US = 500
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWr,
  input  logic        regAddr,
  input  logic [31:0] regWData,
  output logic [31:0] regRData,
  input  logic        usTick,
  input  logic        lineIn,
  output logic        lineOe
);

  ctrlStb_t               stb;
  logic                   ctrlBusy;
  logic                   pulseBusy;
  logic                   pulseDone;
  logic                   pulseBit;
  logic                   firstBit;
  logic [WIDTH_BITS-1:0]  lowUs;
  logic [SAMPLE_BITS-1:0] smpUs;
  logic                   unusedPulseBusy;

  assign unusedPulseBusy = pulseBusy;

  owm_control i_control (
    .clk       (clk),
    .rstN      (rstN),
    .regWr     (regWr),
    .regAddr   (regAddr),
    .cmdOp     (regWData[1:0]),
    .cmdArg    (regWData[CMD_ARG_BIT]),
    .pulseDone (pulseDone),
    .pulseBit  (pulseBit),
    .firstBit  (firstBit),
    .stb       (stb),
    .busy      (ctrlBusy)
  );

  owm_datapath #(
    .WIDTH_BITS  (WIDTH_BITS),
    .SAMPLE_BITS (SAMPLE_BITS)
  ) i_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .regWr     (regWr),
    .regAddr   (regAddr),
    .regWData  (regWData),
    .stb       (stb),
    .ctrlBusy  (ctrlBusy),
    .pulseDone (pulseDone),
    .pulseBit  (pulseBit),
    .lowUs     (lowUs),
    .smpUs     (smpUs),
    .firstBit  (firstBit),
    .regRData  (regRData)
  );

  owm_pulse #(
    .WIDTH_BITS  (WIDTH_BITS),
    .SAMPLE_BITS (SAMPLE_BITS),
    .RECOVERY_US (RECOVERY_US)
  ) i_pulse (
    .clk       (clk),
    .rstN      (rstN),
    .usTick    (usTick),
    .lineIn    (lineIn),
    .start     (stb.startPulse),
    .lowUs     (lowUs),
    .smpUs     (smpUs),
    .busy      (pulseBusy),
    .lineOe    (lineOe),
    .pulseDone (pulseDone),
    .pulseBit  (pulseBit)
  );

endmodule

// File: tb/test_onewire_master.sv
module test_onewire_master;

  localparam int RECOV = 500;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWr = 1'b0;
  logic        regAddr = 1'b0;
  logic [31:0] regWData = '0;
  wire  [31:0] regRData;
  logic        usTick = 1'b0;
  logic [1:0]  tickDiv = 2'd0;
  logic        slaveLow = 1'b0;
  wire         lineOe;
  wire         lineIn = !(lineOe || slaveLow);

  int checks = 0;
  int errors = 0;

  typedef struct {
    int lowTicks;
    int gapTicks;
  } exp_t;

  exp_t expQ[$];
  int   respQ[$];

  always #5 clk = ~clk;

  // one microsecond tick every fourth cycle
  always @(posedge clk) begin
    tickDiv <= tickDiv + 2'd1;
    usTick  <= (tickDiv == 2'd2);
  end

  onewire_master i_onewire_master (
    .clk      (clk),
    .rstN     (rstN),
    .regWr    (regWr),
    .regAddr  (regAddr),
    .regWData (regWData),
    .regRData (regRData),
    .usTick   (usTick),
    .lineIn   (lineIn),
    .lineOe   (lineOe)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, expv);
    end
  endtask

  // Bus device model: each slot answers with the next queued bit
  always @(posedge lineOe) begin
    if (respQ.size() > 0) slaveLow <= (respQ.pop_front() == 0);
    else                  slaveLow <= 1'b0;
  end

  // Scoreboard monitor: low width and inter-pulse gap in ticks
  logic prevOe = 1'b0;
  int   lowCnt = 0;
  int   gapCnt = 0;
  always @(negedge clk) begin
    if (rstN) begin
      if (lineOe && !prevOe) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R5 unexpected pulse", 1, 0);
        end else if (expQ[0].gapTicks >= 0) begin
          check(gapCnt == expQ[0].gapTicks, "R3 recovery gap", gapCnt, expQ[0].gapTicks);
        end
        lowCnt = 0;
      end
      if (!lineOe && prevOe) begin
        if (expQ.size() > 0) begin
          exp_t e;
          e = expQ.pop_front();
          check(lowCnt == e.lowTicks, "R2 low width", lowCnt, e.lowTicks);
        end
        gapCnt = 0;
      end
      if (lineOe && usTick)  lowCnt++;
      if (!lineOe && usTick) gapCnt++;
      prevOe = lineOe;
    end
  end

  task automatic expPulse(input int w, input int g);
    exp_t e;
    e.lowTicks = w;
    e.gapTicks = g;
    expQ.push_back(e);
  endtask

  task automatic wrReg(input logic a, input logic [31:0] d);
    @(negedge clk);
    regAddr  = a;
    regWData = d;
    regWr    = 1'b1;
    @(negedge clk);
    regWr    = 1'b0;
  endtask

  task automatic rdReg(input logic a, output logic [31:0] v);
    regAddr = a;
    #1;
    v = regRData;
  endtask

  task automatic waitDone();
    logic [31:0] v;
    do begin
      @(negedge clk);
      rdReg(1'b1, v);
    end while (!v[1]);
  endtask

  task automatic expectReg(input logic a, input logic [31:0] expv, input string tag);
    logic [31:0] v;
    rdReg(a, v);
    check(v == expv, tag, v, expv);
  endtask

  task automatic doCmd(input logic [1:0] op, input logic arg);
    logic [31:0] v;
    wrReg(1'b1, {29'd0, arg, op});
    rdReg(1'b1, v);
    check(v[1] == 1'b0, "R5 done cleared by command", v[1], 0);
    waitDone();
  endtask

  task automatic triplet(input int a, input int b, input logic dir);
    int w;
    if (a == 0 && b == 0)      w = dir ? 6 : 80;
    else if (a == 0 && b == 1) w = 80;
    else                       w = 6;
    respQ.push_back(a);
    respQ.push_back(b);
    respQ.push_back(1);
    expPulse(6, -1);
    expPulse(6, 13 + RECOV);
    expPulse(w, 13 + RECOV);
    doCmd(2'd3, dir);
    expectReg(1'b1, (32'(a) << 9) | (32'(b) << 8) | 32'h3, "R9 triplet result");
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    check(1'b0, "R3 watchdog timeout", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : stimulus
    logic [31:0] v;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(lineOe == 1'b0, "R1 line released", lineOe, 0);
    expectReg(1'b0, 32'h0, "R1 pulse register");
    expectReg(1'b1, 32'h0, "R1 result register");

    // R2 raw pulse, device answers 0; R5 write while busy ignored
    respQ.push_back(0);
    expPulse(20, -1);
    wrReg(1'b0, (32'd20 << 10) | (32'd5 << 2));
    rdReg(1'b0, v);
    check(v[1] == 1'b0, "R5 done cleared by pulse write", v[1], 0);
    wrReg(1'b0, (32'd7 << 10) | (32'd3 << 2));
    wrReg(1'b1, 32'd2);
    waitDone();
    expectReg(1'b0, (32'd20 << 10) | (32'd5 << 2) | 32'h2, "R2 raw readback and sample");

    // R4 zero fields become one tick, device answers 1
    respQ.push_back(1);
    expPulse(1, -1);
    wrReg(1'b0, 32'h0);
    waitDone();
    expectReg(1'b0, 32'h3, "R4 zero fields sampled high");

    // R6 bus reset with and without presence
    respQ.push_back(0);
    expPulse(500, -1);
    doCmd(2'd0, 1'b0);
    expectReg(1'b1, 32'h002, "R6 presence seen");
    respQ.push_back(1);
    expPulse(500, -1);
    doCmd(2'd0, 1'b0);
    expectReg(1'b1, 32'h103, "R6 no presence");

    // R7 write one and write zero
    respQ.push_back(1);
    expPulse(6, -1);
    doCmd(2'd1, 1'b1);
    expectReg(1'b1, 32'h103, "R7 write one");
    respQ.push_back(0);
    expPulse(80, -1);
    doCmd(2'd1, 1'b0);
    expectReg(1'b1, 32'h002, "R7 write zero");

    // R8 read byte 0xA5, least significant bit first; R3 gaps
    for (int i = 0; i < 8; i++) begin
      respQ.push_back((8'hA5 >> i) & 1);
      expPulse(6, (i == 0) ? -1 : 13 + RECOV);
    end
    doCmd(2'd2, 1'b0);
    expectReg(1'b1, 32'hA503, "R8 read byte");

    // R9 search triplet, every branch of the direction rule
    triplet(0, 0, 1'b1);
    triplet(0, 0, 1'b0);
    triplet(0, 1, 1'b1);
    triplet(1, 0, 1'b0);
    triplet(1, 1, 1'b0);

    repeat (10) @(negedge clk);
    check(expQ.size() == 0, "R2 all expected pulses seen", expQ.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule